// File: doc/BRIEF.md
# Indexed Peripheral Clock-Gate Controller

This block keeps a 64-bit disable map, one bit for each peripheral address slot, and drives one registered clock-enable output per slot. A 1 in the map turns that slot's clock off. Software changes the map through two byte-wide write-only ports. A write to the disable port sets one map bit, chosen by an index, or sets every bit. A write to the enable port clears one map bit, or clears every bit. Because each write names a single slot, software never needs a read-modify-write sequence.

Some slots carry fabric and system-control logic that must keep running. A parameter mask marks these slots. Their map bits stay 0 and their enables stay high, even after a global disable. The map can be read back as a high and a low 32-bit word. Reads of either write port return zero.

Top module: `clk_gate_map`

## Requirements
- R1: After reset every map bit is 0 and every enable output is 1.
- R2: A disable-port write with wr_data[6]=0 sets map bit wr_data[5:0] and leaves every other bit unchanged.
- R3: An enable-port write with wr_data[6]=0 clears map bit wr_data[5:0] and leaves every other bit unchanged.
- R4: A disable-port write with wr_data[6]=1 sets every unprotected map bit, whatever the index field holds.
- R5: An enable-port write with wr_data[6]=1 clears every map bit, whatever the index field holds.
- R6: Bit 7 of wr_data has no effect on either port.
- R7: Slots whose bit is 1 in PROTECT_MASK always read back 0 and always keep their enable at 1.
- R8: If both ports are written in the same cycle, the disable write is applied first and the enable write second, so the enable write wins on any bit both touch.
- R9: A change is seen on slot_clk_en and on the map read-back in the cycle after the write strobe. slot_clk_en[i] is always the inverse of map bit i.
- R10: rd_sel 0 returns map bits 31..0. rd_sel 1 returns map bits 63..32. rd_sel 2 (disable port) and rd_sel 3 (enable port) return zero. rd_data is combinational from rd_sel and the map.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dis_we | input | 1 | Write strobe for the disable (set) port |
| en_we | input | 1 | Write strobe for the enable (clear) port |
| dis_data | input | 8 | Disable-port data: [6] global, [5:0] index, [7] ignored |
| en_data | input | 8 | Enable-port data: [6] global, [5:0] index, [7] ignored |
| rd_sel | input | 2 | Read select: 0 low word, 1 high word, 2 and 3 ports |
| rd_data | output | 32 | Read data |
| slot_clk_en | output | 64 | Per-slot registered clock enable |

## Verification
The bench goes after these corner cases:
- Same-cycle writes to both ports on the same index. A design that lets the set win would leave that slot disabled.
- A global disable followed by reads of the protected slots. A design that does not mask them would turn off the fabric clock.
- Writes with bit 7 set, and global writes with a non-zero index. A design that decodes too many bits would act on the wrong slot, or only on the indexed slot.
- Outputs sampled exactly one cycle after each strobe. This exposes any extra or missing pipeline stage.

// File: rtl/clk_gate_map.sv
module clk_gate_map #(
  parameter int          SLOTS        = 64,
  parameter logic [63:0] PROTECT_MASK = 64'h0000_0000_0000_0003
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        dis_we,
  input  logic        en_we,
  input  logic [7:0]  dis_data,
  input  logic [7:0]  en_data,
  input  logic [1:0]  rd_sel,
  output logic [31:0] rd_data,
  output logic [63:0] slot_clk_en
);
  localparam int IW = $clog2(SLOTS);

  logic [63:0] map_q, after_set, after_clr, set_vec, clr_vec;

  always_comb begin
    set_vec = '0;
    if (dis_we) begin
      if (dis_data[6]) set_vec = '1;
      else             set_vec[dis_data[IW-1:0]] = 1'b1;
    end
    clr_vec = '0;
    if (en_we) begin
      if (en_data[6]) clr_vec = '1;
      else            clr_vec[en_data[IW-1:0]] = 1'b1;
    end
  end

  assign after_set = map_q | set_vec;
  assign after_clr = after_set & ~clr_vec;

  always_ff @(posedge clk) begin
    if (!rst_n) map_q <= '0;
    else        map_q <= after_clr & ~PROTECT_MASK;
  end

  assign slot_clk_en = ~map_q;

  always_comb begin
    case (rd_sel)
      2'd0:    rd_data = map_q[31:0];
      2'd1:    rd_data = map_q[63:32];
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/clk_gate_map_chk.sv
module clk_gate_map_chk #(
  parameter logic [63:0] PROTECT_MASK = 64'h3
) (
  input logic        clk,
  input logic        rst_n,
  input logic        dis_we,
  input logic        en_we,
  input logic [7:0]  dis_data,
  input logic [7:0]  en_data,
  input logic [1:0]  rd_sel,
  input logic [31:0] rd_data,
  input logic [63:0] slot_clk_en
);
  assert_protected_on_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_clk_en & PROTECT_MASK) == PROTECT_MASK);

  assert_global_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (en_we && en_data[6]) |=> (slot_clk_en == '1));

  assert_global_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dis_we && dis_data[6] && !en_we) |=> (slot_clk_en == PROTECT_MASK));

  assert_port_read_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_sel[1] |-> (rd_data == 32'h0));

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!dis_we && !en_we) |=> $stable(slot_clk_en));

  assert_clear_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dis_we && en_we && !en_data[6] && dis_data[5:0] == en_data[5:0])
      |=> slot_clk_en[$past(en_data[5:0])]);
endmodule

bind clk_gate_map clk_gate_map_chk #(.PROTECT_MASK(PROTECT_MASK)) u_chk (.*);

// File: tb/sim_clk_gate_map.sv
module sim_clk_gate_map;
  logic clk = 0, rst_n = 0;
  logic dis_we = 0, en_we = 0;
  logic [7:0] dis_data = 0, en_data = 0;
  logic [1:0] rd_sel = 0;
  logic [31:0] rd_data;
  logic [63:0] slot_clk_en;
  localparam logic [63:0] PM = 64'h0000_0000_0000_0003;

  int tests = 0, fails = 0;
  bit model [64];
  bit done = 0;

  always #5 clk = ~clk;

  clk_gate_map #(.PROTECT_MASK(PM)) u0 (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] model_vec();
    logic [63:0] v;
    for (int i = 0; i < 64; i++) v[i] = model[i];
    return v;
  endfunction

  task automatic do_op(input bit dw, input logic [7:0] dd, input bit ew, input logic [7:0] ed,
                       input string req);
    @(negedge clk);
    dis_we = dw; dis_data = dd; en_we = ew; en_data = ed;
    if (dw) begin
      if (dd[6]) for (int i = 0; i < 64; i++) model[i] = 1;
      else model[int'(dd[5:0])] = 1;
    end
    if (ew) begin
      if (ed[6]) for (int i = 0; i < 64; i++) model[i] = 0;
      else model[int'(ed[5:0])] = 0;
    end
    for (int i = 0; i < 64; i++) if (PM[i]) model[i] = 0;
    @(negedge clk);
    dis_we = 0; en_we = 0;
    chk({req, " R9 enable"}, slot_clk_en, ~model_vec());
    rd_sel = 0; #1 chk({req, " R10 lo"}, {32'h0, rd_data}, {32'h0, model_vec()[31:0]});
    rd_sel = 1; #1 chk({req, " R10 hi"}, {32'h0, rd_data}, {32'h0, model_vec()[63:32]});
    rd_sel = 2; #1 chk("R10 dis port read", {32'h0, rd_data}, 64'h0);
    rd_sel = 3; #1 chk("R10 en port read", {32'h0, rd_data}, 64'h0);
  endtask

  initial begin
    #200000;
    fails++; tests++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) model[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset enables", slot_clk_en, '1);
    do_op(1, 8'd5, 0, 0, "R2 set 5");
    do_op(1, 8'd63, 0, 0, "R2 set 63");
    do_op(1, 8'd0, 0, 0, "R7 set protected 0");
    do_op(0, 0, 1, 8'd5, "R3 clear 5");
    do_op(1, 8'h80 | 8'd40, 0, 0, "R6 bit7 set 40");
    do_op(0, 0, 1, 8'h80 | 8'd40, "R6 bit7 clear 40");
    do_op(1, 8'h40 | 8'd9, 0, 0, "R4 global set");
    chk("R7 protected after global", slot_clk_en & PM, PM);
    do_op(0, 0, 1, 8'd33, "R3 clear 33");
    do_op(1, 8'd33, 1, 8'd33, "R8 both same idx");
    do_op(1, 8'd20, 1, 8'd33, "R8 both diff idx");
    do_op(1, 8'h40, 1, 8'd7, "R8 global set + clear 7");
    do_op(0, 0, 1, 8'h40 | 8'd12, "R5 global clear");
    for (int k = 0; k < 30; k++)
      do_op(k[0], 8'((k * 37) & 8'hBF), k[1], 8'((k * 11) & 8'hBF), "R2/R3 sweep");
    do_op(0, 0, 1, 8'h7F, "R5 value 127");
    do_op(0, 0, 0, 0, "R9 idle hold");
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule